// File: doc/BRIEF.md
# Three-Level PWM Gate-Drive Sequencer

This block runs the two gate enables of a single synchronous buck phase: the high-side enable and the low-side enable. A PWM command arrives already sorted by an analog front end into three levels: high, low and a mid-rail float. Beside it come an active-high run enable, a synchronous/diode-emulation select, a supply-good flag and two feedback bits. Each feedback bit reports that one gate has discharged. The sequencer never turns both gates on together. It turns a gate on only after the opposite gate reports discharged and a minimum dead count has then elapsed.

A float on the PWM command keeps the last gate state for a programmable hold-off. Once the float has lasted the full hold-off, both gates are blanked, which parks the phase without ringing. When diode emulation is selected, the low side is never driven. When supply-good falls, both outputs drop in the same cycle without waiting for a clock edge. Every input goes through a two-flop synchroniser.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: While reset is held and directly after it, both `gh_on` and `gl_on` are 0.
- R2: While `run_en` is 0, both gates are off whatever the values of `pwm_lvl` and `sync_mode`; if a gate was on, it drops 3 clock edges after `run_en` falls.
- R3: With `pwm_lvl` = 2'b01 (high), the low gate turns off first, 3 edges after the change, and the high gate turns on afterwards.
- R4: With `pwm_lvl` = 2'b00 (low) and `sync_mode` = 1, the high gate turns off 3 edges after the change, and the low gate turns on afterwards.
- R5: With `sync_mode` = 0 (diode emulation), `gl_on` is never 1. A high command still turns on `gh_on`, and a low command leaves both gates off.
- R6: With `pwm_lvl` = 2'b10 (float), both gates keep their state until the float has lasted HOLDOFF synchronised cycles; both are off HOLDOFF+3 edges after the float begins, whatever `sync_mode` is.
- R7: A float that ends before the hold-off expires causes no change on either gate, and the hold-off count restarts.
- R8: A gate turns on only while the feedback bit of the opposite gate reports discharged (1); with that bit held at 0 the gate stays off.
- R9: After the opposite gate's discharged bit is seen, the gate waits DEAD_MIN further cycles, so a high-to-low or low-to-high handover takes 6+DEAD_MIN edges when the feedback follows the gates directly.
- R10: When `supply_ok` is 0, both outputs are 0 within the same cycle, and they stay 0 until `supply_ok` returns to 1.
- R11: The code `pwm_lvl` = 2'b11 is treated exactly as float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | Classified PWM: 00 low, 01 high, 10/11 float |
| run_en | input | 1 | 1 runs the phase, 0 holds both gates off |
| sync_mode | input | 1 | 1 synchronous, 0 diode emulation (low side unused) |
| supply_ok | input | 1 | Supply above lockout threshold |
| gh_dis | input | 1 | High gate reported discharged |
| gl_dis | input | 1 | Low gate reported discharged |
| gh_on | output | 1 | High-side gate enable |
| gl_on | output | 1 | Low-side gate enable |

## Verification
The hardest state to reach is a float that ends just short of the hold-off while a gate is on. The bench drives the float for fewer cycles than HOLDOFF and then restores the same level, and confirms that neither gate moves. The shoot-through guard is also hard to reach, because a well-behaved feedback path always discharges. The bench therefore holds the low gate's discharged bit at 0 during a low-to-high handover, and then releases it and measures the turn-on delay. A sweep over every run, mode and PWM code checks the settled gate state against a value the bench computes itself.

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl #(
  parameter int HOLDOFF  = 19,
  parameter int DEAD_MIN = 1,
  parameter int SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic       run_en,
  input  logic       sync_mode,
  input  logic       supply_ok,
  input  logic       gh_dis,
  input  logic       gl_dis,
  output logic       gh_on,
  output logic       gl_on
);
  localparam int CW = $clog2(HOLDOFF + 1);
  localparam int DW = $clog2(DEAD_MIN + 2);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLDOFF);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD_MIN);

  logic [6:0] sq [SYNC];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < SYNC; i++) sq[i] <= '0;
    else begin
      sq[0] <= {pwm_lvl, run_en, sync_mode, supply_ok, gh_dis, gl_dis};
      for (int i = 1; i < SYNC; i++) sq[i] <= sq[i-1];
    end

  logic [1:0] pwm_s;
  logic en_s, sm_s, ok_s, fbh_s, fbl_s;
  assign {pwm_s, en_s, sm_s, ok_s, fbh_s, fbl_s} = sq[SYNC-1];

  logic [CW-1:0] flt_cnt;
  logic [DW-1:0] dt_cnt;
  logic last_h, last_l, gh_q, gl_q;

  wire flt     = pwm_s[1];
  wire expired = (flt_cnt == HOLD_V);
  wire live    = en_s & ok_s;
  wire dec_h   = live & (pwm_s == 2'b01);
  wire dec_l   = live & sm_s & (pwm_s == 2'b00);
  wire req_h   = flt ? (last_h & ~expired & live)        : dec_h;
  wire req_l   = flt ? (last_l & ~expired & live & sm_s) : dec_l;
  wire dt_ok   = (dt_cnt >= DEAD_V);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_cnt <= '0;
      dt_cnt  <= '0;
      last_h  <= 1'b0;
      last_l  <= 1'b0;
      gh_q    <= 1'b0;
      gl_q    <= 1'b0;
    end else begin
      flt_cnt <= !flt ? '0 : (expired ? flt_cnt : flt_cnt + 1'b1);
      if (!flt) begin
        last_h <= dec_h;
        last_l <= dec_l;
      end
      gh_q <= req_h & (gh_q | (~gl_q & fbl_s & dt_ok));
      gl_q <= req_l & (gl_q | (~gh_q & fbh_s & dt_ok));
      if (gh_q | gl_q)
        dt_cnt <= '0;
      else if ((req_h & fbl_s) | (req_l & fbh_s))
        dt_cnt <= (dt_cnt == {DW{1'b1}}) ? dt_cnt : dt_cnt + 1'b1;
      else
        dt_cnt <= '0;
    end

  assign gh_on = gh_q & supply_ok;
  assign gl_on = gl_q & supply_ok;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh_q && gl_q)); // R3
  AST_GH_AFTER_FB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh_q) |-> $past(fbl_s) && !$past(gl_q)); // R8
  AST_GL_AFTER_FB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_q) |-> $past(fbh_s) && !$past(gh_q)); // R8
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !gh_q && !gl_q); // R2
  AST_DIODE_NO_GL: assert property (@(posedge clk) disable iff (!rst_n)
    !sm_s |=> !gl_q); // R5
  AST_HOLDOFF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    flt && expired |=> !gh_q && !gl_q); // R6
  AST_SUPPLY_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_s |=> !gh_q && !gl_q); // R10
endmodule

// File: tb/pwm_gate_ctrl_test.sv
module pwm_gate_ctrl_test;
  localparam int H = 5;
  localparam int D = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] pwm_lvl = 2'b00;
  logic run_en = 0, sync_mode = 1, supply_ok = 1;
  logic stuck_h = 0, stuck_l = 0;
  logic gh_on, gl_on;
  logic gh_dis, gl_dis;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;
  assign gh_dis = ~gh_on & ~stuck_h;
  assign gl_dis = ~gl_on & ~stuck_l;

  pwm_gate_ctrl #(.HOLDOFF(H), .DEAD_MIN(D), .SYNC(2)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .run_en(run_en),
    .sync_mode(sync_mode), .supply_ok(supply_ok), .gh_dis(gh_dis),
    .gl_dis(gl_dis), .gh_on(gh_on), .gl_on(gl_on));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // first edge index at which sel output equals val (sel 0 = gh, 1 = gl)
  task automatic edge_of(input int sel, input logic val, output int n);
    n = -1;
    for (int k = 1; k <= 60; k++) begin
      @(posedge clk); #1;
      if (n < 0 && ((sel == 0) ? gh_on : gl_on) == val) n = k;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic g;
    cyc(3);
    check("R1 gh in reset", gh_on, 0);
    check("R1 gl in reset", gl_on, 0);
    rst_n = 1;
    cyc(1);
    check("R1 gh after reset", gh_on, 0);
    check("R1 gl after reset", gl_on, 0);

    run_en = 1; cyc(30);
    check("R4 low level gl settled", gl_on, 1);

    pwm_lvl = 2'b01;
    fork edge_of(1, 1'b0, n); join
    check("R3 gl off edge", n, 3);
    pwm_lvl = 2'b00; cyc(30);
    pwm_lvl = 2'b01;
    edge_of(0, 1'b1, n);
    check("R9 gh on after dead count", n, 6 + D);

    pwm_lvl = 2'b00;
    edge_of(0, 1'b0, n);
    check("R4 gh off edge", n, 3);
    pwm_lvl = 2'b01; cyc(30);
    pwm_lvl = 2'b00;
    edge_of(1, 1'b1, n);
    check("R9 gl on after dead count", n, 6 + D);

    pwm_lvl = 2'b10;
    edge_of(1, 1'b0, n);
    check("R6 float blanks gl", n, H + 3);

    pwm_lvl = 2'b01; cyc(30);
    pwm_lvl = 2'b11;
    edge_of(0, 1'b0, n);
    check("R11 code 11 blanks gh", n, H + 3);

    pwm_lvl = 2'b01; cyc(30);
    pwm_lvl = 2'b10; cyc(H - 2);
    pwm_lvl = 2'b01;
    g = 1;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #1;
      if (!gh_on || gl_on) g = 0;
    end
    check("R7 short float no glitch", g, 1);
    pwm_lvl = 2'b10; cyc(H - 2);
    pwm_lvl = 2'b01; cyc(30);
    check("R7 count restarted", gh_on, 1);

    supply_ok = 0; #1;
    check("R10 gh clamped same cycle", gh_on, 0);
    cyc(20);
    check("R10 gh held low", gh_on, 0);
    check("R10 gl held low", gl_on, 0);
    supply_ok = 1; cyc(30);
    check("R10 gh back after supply", gh_on, 1);

    pwm_lvl = 2'b00; cyc(30);
    stuck_l = 1;
    pwm_lvl = 2'b01; cyc(40);
    check("R8 gh blocked without fb", gh_on, 0);
    check("R8 gl released", gl_on, 0);
    stuck_l = 0;
    edge_of(0, 1'b1, n);
    check("R8 gh on after fb release", n, 3 + D);

    run_en = 0;
    edge_of(0, 1'b0, n);
    check("R2 disable drops gh", n, 3);

    sync_mode = 0; run_en = 1; pwm_lvl = 2'b01; cyc(30);
    check("R5 gh in diode mode", gh_on, 1);
    pwm_lvl = 2'b00;
    g = 1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (gl_on || (k > 3 && gh_on)) g = 0;
    end
    check("R5 low leaves both off", g, 1);
    @(negedge clk);

    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 4; p++) begin
          run_en = e[0]; sync_mode = s[0]; pwm_lvl = p[1:0];
          cyc(40);
          check($sformatf("R2 R5 R6 R11 sweep gh e%0d s%0d p%0d", e, s, p),
                gh_on, (e == 1 && p == 1) ? 1 : 0);
          check($sformatf("R2 R5 R6 R11 sweep gl e%0d s%0d p%0d", e, s, p),
                gl_on, (e == 1 && s == 1 && p == 0) ? 1 : 0);
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule